// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Controller

This block gives a host eight general-purpose pins that it configures through five 8-bit control registers on a small synchronous register bus. Each pin is set up on its own. It can be an input or an output. An output drives the level the host programmed, or it floats when its float bit is set, so several sources can share a wire. An input passes through a two-flop synchroniser. Its polarity can then be flipped, and it can be read back or used to raise an interrupt.

The per-pin interrupts are merged into one level request. The block also registers a fixed 3-bit code for that request, which the host-side status logic places in a serial channel's interrupt field. A pad ring sits outside the block. It receives the output value and an output-enable per pin, and it returns the raw pin levels.

Top module: `mpio_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all five registers read 0x00, `pad_oe` is 0xFF, `pad_out` is 0x00, `irq_req` is 0 and `irq_code` is 3'b000.
- R2: A write with `wr_en` high stores `wdata` at the rising edge. The addresses are: 0 direction (1 = input), 1 level, 2 float, 3 invert, 4 interrupt enable. A read returns the addressed register on `rdata` one cycle after `addr` is presented. Addresses 5 to 7 read 0x00, and a write to them changes no register.
- R3: A pin whose direction bit is 1 has `pad_oe` low and `pad_out` low.
- R4: A pin whose direction bit is 0 and whose float bit is 0 has `pad_oe` high and drives its level bit on `pad_out`.
- R5: An output pin whose float bit is 1 has `pad_oe` low.
- R6: Reading address 1 returns the synchronised, polarity-adjusted pin level for each input pin and the programmed level bit for each output pin.
- R7: A change on `pad_in` appears in the address-1 readback three clock edges after the change: two synchroniser edges and one read register.
- R8: An invert bit of 1 flips an input pin's value, both in the readback and in its interrupt sense.
- R9: A pin requests an interrupt while it is an input, its enable bit is 1 and its adjusted value is 1. `irq_req` is the registered OR of all pin requests. It rises one edge after an enable write that finds the pin already high.
- R10: `irq_code` is 3'b011 while `irq_req` is high and 3'b000 otherwise.
- R11: On output pins, the enable and invert bits never cause an interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for `addr` |
| pad_in | input | 8 | Raw pin levels from the pads |
| pad_out | output | 8 | Output value per pin |
| pad_oe | output | 8 | Output enable per pin, 1 = drive |
| irq_req | output | 1 | Combined interrupt request |
| irq_code | output | 3 | Encoded interrupt status for the host |

## Verification
A host write to the enable register can land in the same cycle that a synchronised input edge reaches the interrupt logic. The bench provokes this by raising an enabled input pin, then timing a write that clears the enable so that it takes effect on the edge where the synchroniser output turns high. The expected result is that `irq_req` and `irq_code` never leave zero. The reverse race is also tested: enabling a pin that is already high must raise the request exactly one edge later.

// File: rtl/mpio_pkg.sv
package mpio_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR = 3'd0,
    REG_LVL = 3'd1,
    REG_FLT = 3'd2,
    REG_INV = 3'd3,
    REG_IEN = 3'd4
  } mpio_reg_e;
endpackage

// File: rtl/mpio_sync.sv
module mpio_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] din,
  output logic [NPINS-1:0] dout
);
  logic [NPINS-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/mpio_regfile.sv
module mpio_regfile
  import mpio_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  pin_adj,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  lvl_q,
  output logic [NPINS-1:0]  flt_q,
  output logic [NPINS-1:0]  inv_q,
  output logic [NPINS-1:0]  ien_q,
  output logic [NPINS-1:0]  rdata
);
  logic [NPINS-1:0] lvl_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      lvl_q <= '0;
      flt_q <= '0;
      inv_q <= '0;
      ien_q <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_DIR: dir_q <= wdata;
        REG_LVL: lvl_q <= wdata;
        REG_FLT: flt_q <= wdata;
        REG_INV: inv_q <= wdata;
        REG_IEN: ien_q <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_view
    assign lvl_view[p] = dir_q[p] ? pin_adj[p] : lvl_q[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        REG_DIR: rdata <= dir_q;
        REG_LVL: rdata <= lvl_view;
        REG_FLT: rdata <= flt_q;
        REG_INV: rdata <= inv_q;
        REG_IEN: rdata <= ien_q;
        default: rdata <= '0;
      endcase
    end
  end

  AST_DIR_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_DIR) |=> (dir_q == $past(wdata))); // R2

  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr > REG_IEN) |=> ($stable(dir_q) && $stable(lvl_q) && $stable(flt_q)
                                    && $stable(inv_q) && $stable(ien_q))); // R2
endmodule

// File: rtl/mpio_pad.sv
module mpio_pad #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] lvl_q,
  input  logic [NPINS-1:0] flt_q,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[p] <= 1'b0;
        pad_oe[p]  <= 1'b1;
      end else begin
        pad_out[p] <= lvl_q[p] & ~dir_q[p];
        pad_oe[p]  <= ~dir_q[p] & ~flt_q[p];
      end
    end
  end

  AST_INPUT_NOT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & $past(dir_q)) == '0)); // R3

  AST_FLOAT_RELEASES: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & $past(flt_q)) == '0)); // R5
endmodule

// File: rtl/mpio_irq.sv
module mpio_irq #(
  parameter int          NPINS    = 8,
  parameter int          CODE_W   = 3,
  parameter logic [CODE_W-1:0] IRQ_CODE = 3'b011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_adj,
  input  logic [NPINS-1:0]  dir_q,
  input  logic [NPINS-1:0]  ien_q,
  output logic              irq_req,
  output logic [CODE_W-1:0] irq_code
);
  logic [NPINS-1:0] pin_irq;

  for (genvar p = 0; p < NPINS; p++) begin : g_src
    assign pin_irq[p] = pin_adj[p] & dir_q[p] & ien_q[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      irq_code <= '0;
    end else begin
      irq_req  <= |pin_irq;
      irq_code <= (|pin_irq) ? IRQ_CODE : '0;
    end
  end

  AST_IRQ_NEEDS_ENABLED_INPUT: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(|(ien_q & dir_q))); // R11

  AST_IRQ_NEEDS_HIGH_PIN: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(|(pin_adj & dir_q))); // R9
endmodule

// File: rtl/mpio_ctrl.sv
module mpio_ctrl
  import mpio_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W      = 3,
  parameter logic [CODE_W-1:0] IRQ_CODE = 3'b011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_req,
  output logic [CODE_W-1:0] irq_code
);
  logic [NPINS-1:0] dir_q, lvl_q, flt_q, inv_q, ien_q;
  logic [NPINS-1:0] pin_sync, pin_adj;

  mpio_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pad_in), .dout(pin_sync)
  );

  assign pin_adj = pin_sync ^ inv_q;

  mpio_regfile #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pin_adj(pin_adj), .dir_q(dir_q), .lvl_q(lvl_q), .flt_q(flt_q),
    .inv_q(inv_q), .ien_q(ien_q), .rdata(rdata)
  );

  mpio_pad #(.NPINS(NPINS)) u_pad (
    .clk(clk), .rst(rst), .dir_q(dir_q), .lvl_q(lvl_q), .flt_q(flt_q),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  mpio_irq #(.NPINS(NPINS), .CODE_W(CODE_W), .IRQ_CODE(IRQ_CODE)) u_irq (
    .clk(clk), .rst(rst), .pin_adj(pin_adj), .dir_q(dir_q), .ien_q(ien_q),
    .irq_req(irq_req), .irq_code(irq_code)
  );

  AST_CODE_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_code == IRQ_CODE)); // R10

  AST_CODE_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_code == '0)); // R10
endmodule

// File: tb/mpio_ctrl_tb.sv
module mpio_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe;
  logic       irq_req;
  logic [2:0] irq_code;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  mpio_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_req(irq_req), .irq_code(irq_code)
  );

  // fields: dir, lvl, flt, inv, ien, pin, exp_oe, exp_out, exp_rd, exp_irq
  localparam int NV = 10;
  localparam logic [72:0] VEC [NV] = '{
    {8'h00, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hA5, 8'hA5, 1'b0},
    {8'hFF, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h3C, 8'h00, 8'h00, 8'h3C, 1'b0},
    {8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h3C, 8'h00, 8'h00, 8'hC3, 1'b0},
    {8'hF0, 8'h0F, 8'h0C, 8'h00, 8'h00, 8'h50, 8'h03, 8'h0F, 8'h5F, 1'b0},
    {8'hF0, 8'h00, 8'h00, 8'h00, 8'h10, 8'h10, 8'h0F, 8'h00, 8'h10, 1'b1},
    {8'hF0, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h00, 8'h0F, 8'h00, 8'h00, 1'b0},
    {8'hF0, 8'h00, 8'h00, 8'h0F, 8'h0F, 8'h00, 8'h0F, 8'h00, 8'h00, 1'b0},
    {8'h01, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'hFE, 8'h00, 8'h01, 1'b1},
    {8'h01, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'hFE, 8'h00, 8'h00, 1'b0},
    {8'h80, 8'hFF, 8'h7F, 8'h00, 8'h80, 8'h80, 8'h00, 8'h7F, 8'hFF, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state while reset is high
    check("R1 oe", pad_oe, 8'hFF);
    check("R1 out", pad_out, 8'h00);
    check("R1 irq", {7'd0, irq_req}, 8'h00);
    check("R1 code", {5'd0, irq_code}, 8'h00);
    rst = 1'b0;
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], r);
      check("R1 reg", r, 8'h00);
    end

    // R2 readback of plain registers and unmapped addresses
    wr(3'd0, 8'h5A); wr(3'd2, 8'hC3); wr(3'd3, 8'h81); wr(3'd4, 8'h24);
    rd(3'd0, r); check("R2 dir", r, 8'h5A);
    rd(3'd2, r); check("R2 flt", r, 8'hC3);
    rd(3'd3, r); check("R2 inv", r, 8'h81);
    rd(3'd4, r); check("R2 ien", r, 8'h24);
    wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd5, r); check("R2 unmapped read", r, 8'h00);
    rd(3'd0, r); check("R2 dir after unmapped write", r, 8'h5A);
    rd(3'd4, r); check("R2 ien after unmapped write", r, 8'h24);

    // Vector table: R3 R4 R5 R6 R8 R9 R10 R11
    for (int v = 0; v < NV; v++) begin
      wr(3'd0, VEC[v][72:65]);
      wr(3'd1, VEC[v][64:57]);
      wr(3'd2, VEC[v][56:49]);
      wr(3'd3, VEC[v][48:41]);
      wr(3'd4, VEC[v][40:33]);
      pad_in = VEC[v][32:25];
      repeat (4) @(negedge clk);
      check("R3/R5 oe", pad_oe, VEC[v][24:17]);
      check("R4 out", pad_out, VEC[v][16:9]);
      check("R9/R11 irq", {7'd0, irq_req}, {7'd0, VEC[v][0]});
      check("R10 code", {5'd0, irq_code}, VEC[v][0] ? 8'h03 : 8'h00);
      rd(3'd1, r);
      check("R6/R8 level read", r, VEC[v][8:1]);
    end

    // R7 synchroniser latency
    wr(3'd4, 8'h00); wr(3'd3, 8'h00); wr(3'd2, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h01);
    pad_in = 8'h00;
    rd(3'd1, r);
    repeat (3) @(negedge clk);
    pad_in = 8'h01;
    @(negedge clk); check("R7 after edge 1", rdata, 8'h00);
    @(negedge clk); check("R7 after edge 2", rdata, 8'h00);
    @(negedge clk); check("R7 after edge 3", rdata, 8'h01);

    // R9 enable written while pin already high: request one edge later
    wr(3'd4, 8'h01);
    check("R9 irq same edge as enable", {7'd0, irq_req}, 8'h00);
    @(negedge clk);
    check("R9 irq one edge after enable", {7'd0, irq_req}, 8'h01);
    check("R10 code active", {5'd0, irq_code}, 8'h03);

    // R9 race: enable cleared on the edge where the synchronised input rises
    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    check("R9 irq drops", {7'd0, irq_req}, 8'h00);
    pad_in = 8'h01;
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd4; wdata = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 race irq edge 2", {7'd0, irq_req}, 8'h00);
    @(negedge clk);
    check("R9 race irq edge 3", {7'd0, irq_req}, 8'h00);
    check("R10 race code", {5'd0, irq_code}, 8'h00);
    @(negedge clk);
    check("R9 race irq later", {7'd0, irq_req}, 8'h00);

    finish_run();
  end
endmodule